// File: doc/BRIEF.md
# External Request Bus Handover Controller

This block sits on the agent side of a processor bus that has exactly one master. When local logic needs to run an independent transfer over the shared address/data and command buses, the block raises an active-low request line toward the processor. It then waits for the processor's one-cycle release pulse. From the following cycle it drives the buses with whatever the local logic presents. When the local logic reports that it is finished, the block spends one cycle placing a dedicated release-null code on the command bus with its active-low valid strobe asserted, and it floats the buses again in the cycle after that.

The same release pulse also arrives when the processor issues a read address cycle. If no request is on the wire when the pulse arrives, the block treats the pulse as a read handover. It drives the buses with valid deasserted until the local side supplies read words. Each word goes out with valid asserted, and the buses are released one cycle after the last word. A programmable quiet time keeps the request line high for a minimum number of cycles after every grant. The bus outputs come with a drive-enable rather than as true tri-states, which suits a pad ring or an FPGA I/O wrapper.

Top module: `ext_bus_handover`

## Requirements
- R1: During and after synchronous reset (`rst` high): `ext_rqst_n_o`=1, `valid_in_n_o`=1, `bus_oe_o`=0, `own_o`=0, and `sys_ad_o` and `sys_cmd_o` are zero.
- R2: When idle, with the quiet time elapsed and `xreq_i` high, `ext_rqst_n_o` goes low one cycle later. It stays low until a `release_n_i` low cycle is sampled.
- R3: When `release_n_i` is sampled low while the request is out, the next cycle has `ext_rqst_n_o`=1, `bus_oe_o`=1 and `own_o`=1.
- R4: After each grant, `ext_rqst_n_o` stays high for at least `GAP_CYC` cycles (default 4), counted from the grant edge. A request made earlier than that waits.
- R5: While `own_o`=1, `valid_in_n_o` stays 1. `sys_ad_o` and `sys_cmd_o` show `x_ad_i` and `x_cmd_i` as they were sampled at the previous clock edge.
- R6: A `x_done_i` sampled while `own_o`=1 produces one cycle with `sys_cmd_o`=`NULL_CODE` (default 9'h1F0), `sys_ad_o`=0, `valid_in_n_o`=0 and `bus_oe_o`=1. The cycle after it has `bus_oe_o`=0 and `valid_in_n_o`=1.
- R7: A `release_n_i` low sampled while idle with no request out starts read ownership. From the next cycle `bus_oe_o`=1, `valid_in_n_o`=1 and the buses carry zero until read data is supplied.
- R8: During read ownership, each sampled `rd_vld_i` puts `rd_ad_i` and `rd_cmd_i` on the buses with `valid_in_n_o`=0 one cycle later. When that word also has `rd_last_i`, the buses are released (`bus_oe_o`=0) in the cycle after its data cycle.
- R9: A `release_n_i` pulse that arrives while the block already drives the buses has no effect. The request line also stays high whenever `bus_oe_o`=1.
- R10: If `release_n_i` low and `xreq_i` arrive in the same idle cycle, the pulse is a read handover. The request is raised only after that read completes, if `xreq_i` is still high.
- R11: `rd_vld_i` outside read ownership and `x_done_i` outside independent ownership have no effect on any output. Local commands never equal `NULL_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all activity on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| xreq_i | input | 1 | Local logic wants an independent transfer |
| x_ad_i | input | AD_W | Address/data word for the independent transfer |
| x_cmd_i | input | CMD_W | Command word for the independent transfer |
| x_done_i | input | 1 | Independent transfer finished, hand the bus back |
| own_o | output | 1 | Block owns the bus for an independent transfer |
| rd_vld_i | input | 1 | Read return word available |
| rd_last_i | input | 1 | Current read word is the final one |
| rd_ad_i | input | AD_W | Read return data |
| rd_cmd_i | input | CMD_W | Data-type command for the read word |
| release_n_i | input | 1 | Processor release pulse, active low |
| ext_rqst_n_o | output | 1 | Bus request to the processor, active low |
| valid_in_n_o | output | 1 | Valid strobe toward the processor, active low |
| sys_ad_o | output | AD_W | Shared address/data bus value |
| sys_cmd_o | output | CMD_W | Shared command bus value |
| bus_oe_o | output | 1 | Drive enable for the shared buses |

## Verification
Directed sequences run a full independent transfer with a release that comes several cycles late, a block read whose data words arrive with a gap between them, and a one-word read that answers in the first owned cycle. Between them, these sequences separate the request, grant, data and hand-back phases. Further sequences pulse release while the bus is owned, and make release and a fresh request arrive in the same idle cycle. Another holds the request input high across back-to-back transfers, which exposes the quiet time. A long pseudo-random phase then mixes every input, including stray done and read-valid strobes, and checks on every clock against a behavioural model built from the requirements.

// File: rtl/xh_pkg.sv
package xh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XOWN,
    ST_ROWN,
    ST_RET
  } own_st_t;

  typedef enum logic [2:0] {
    DRV_OFF,
    DRV_XFER,
    DRV_WAIT,
    DRV_RDAT,
    DRV_NULL
  } drv_sel_t;

endpackage

// File: rtl/xh_req_ctl.sv
module xh_req_ctl #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req_i,
  input  logic grant_x_i,
  output logic ext_rqst_n_o,
  output logic gap_ok_o
);

  localparam int CNT_W = $clog2(GAP_CYC + 2);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC);

  logic [CNT_W-1:0] gap_cnt;
  logic             rqst_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rqst_n_q <= 1'b1;
      gap_cnt  <= '0;
    end else if (grant_x_i) begin
      rqst_n_q <= 1'b1;
      gap_cnt  <= GAP_LOAD;
    end else begin
      if (start_req_i) rqst_n_q <= 1'b0;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign ext_rqst_n_o = rqst_n_q;
  assign gap_ok_o     = (gap_cnt == '0);

  // R2: once out, the request holds until a grant is taken
  p_hold_req_r2: assert property (@(posedge clk) disable iff (rst)
    (!ext_rqst_n_o && !grant_x_i) |=> !ext_rqst_n_o);

  // R3: grant drops the request on the next edge
  p_drop_on_grant_r3: assert property (@(posedge clk) disable iff (rst)
    grant_x_i |=> ext_rqst_n_o);

  generate
    if (GAP_CYC > 0) begin : g_gap_chk
      // R4: request line is never re-asserted right after release
      p_quiet_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_rqst_n_o) |=> ext_rqst_n_o);
    end
  endgenerate

endmodule

// File: rtl/xh_own_fsm.sv
module xh_own_fsm
  import xh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     release_n_i,
  input  logic     xreq_i,
  input  logic     x_done_i,
  input  logic     rd_vld_i,
  input  logic     rd_last_i,
  input  logic     gap_ok_i,
  output logic     start_req_o,
  output logic     grant_x_o,
  output drv_sel_t sel_nxt_o,
  output logic     own_o
);

  own_st_t st, st_nxt;
  logic    rel;

  assign rel = !release_n_i;

  always_comb begin
    st_nxt      = st;
    start_req_o = 1'b0;
    grant_x_o   = 1'b0;
    sel_nxt_o   = DRV_OFF;
    unique case (st)
      ST_IDLE: begin
        if (rel) begin
          st_nxt    = ST_ROWN;
          sel_nxt_o = DRV_WAIT;
        end else if (xreq_i && gap_ok_i) begin
          st_nxt      = ST_REQ;
          start_req_o = 1'b1;
        end
      end
      ST_REQ: begin
        if (rel) begin
          st_nxt    = ST_XOWN;
          grant_x_o = 1'b1;
          sel_nxt_o = DRV_XFER;
        end
      end
      ST_XOWN: begin
        if (x_done_i) begin
          st_nxt    = ST_RET;
          sel_nxt_o = DRV_NULL;
        end else begin
          sel_nxt_o = DRV_XFER;
        end
      end
      ST_ROWN: begin
        if (rd_vld_i) begin
          sel_nxt_o = DRV_RDAT;
          if (rd_last_i) st_nxt = ST_RET;
        end else begin
          sel_nxt_o = DRV_WAIT;
        end
      end
      ST_RET: begin
        st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  assign own_o = (st == ST_XOWN);

  // R9: a release pulse cannot end independent ownership
  p_xown_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XOWN && !x_done_i) |=> (st == ST_XOWN));

  // R9: read ownership is left only through a last data word
  p_rown_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ROWN && !(rd_vld_i && rd_last_i)) |=> (st == ST_ROWN));

  // R10: a request is only launched from idle with no release present
  p_start_clean_r10: assert property (@(posedge clk) disable iff (rst)
    start_req_o |-> (release_n_i && st == ST_IDLE));

endmodule

// File: rtl/xh_bus_drv.sv
module xh_bus_drv
  import xh_pkg::*;
#(
  parameter int              AD_W      = 64,
  parameter int              CMD_W     = 9,
  parameter logic [CMD_W-1:0] NULL_CODE = 9'h1F0
) (
  input  logic             clk,
  input  logic             rst,
  input  drv_sel_t         sel_i,
  input  logic [AD_W-1:0]  x_ad_i,
  input  logic [CMD_W-1:0] x_cmd_i,
  input  logic [AD_W-1:0]  rd_ad_i,
  input  logic [CMD_W-1:0] rd_cmd_i,
  output logic [AD_W-1:0]  sys_ad_o,
  output logic [CMD_W-1:0] sys_cmd_o,
  output logic             bus_oe_o,
  output logic             valid_in_n_o
);

  logic [AD_W-1:0]  ad_d;
  logic [CMD_W-1:0] cmd_d;
  logic             oe_d, vin_n_d;

  always_comb begin
    ad_d    = '0;
    cmd_d   = '0;
    oe_d    = 1'b0;
    vin_n_d = 1'b1;
    unique case (sel_i)
      DRV_XFER: begin
        ad_d  = x_ad_i;
        cmd_d = x_cmd_i;
        oe_d  = 1'b1;
      end
      DRV_WAIT: oe_d = 1'b1;
      DRV_RDAT: begin
        ad_d    = rd_ad_i;
        cmd_d   = rd_cmd_i;
        oe_d    = 1'b1;
        vin_n_d = 1'b0;
      end
      DRV_NULL: begin
        cmd_d   = NULL_CODE;
        oe_d    = 1'b1;
        vin_n_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_ad_o     <= '0;
      sys_cmd_o    <= '0;
      bus_oe_o     <= 1'b0;
      valid_in_n_o <= 1'b1;
    end else begin
      sys_ad_o     <= ad_d;
      sys_cmd_o    <= cmd_d;
      bus_oe_o     <= oe_d;
      valid_in_n_o <= vin_n_d;
    end
  end

  // R6: the valid strobe is only driven on an owned bus
  p_vin_needs_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_in_n_o |-> bus_oe_o);

  // R6: the hand-back cycle is followed by a floated bus
  p_null_then_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!valid_in_n_o && sys_cmd_o == NULL_CODE) |=> (!bus_oe_o && valid_in_n_o));

endmodule

// File: rtl/ext_bus_handover.sv
module ext_bus_handover
  import xh_pkg::*;
#(
  parameter int               AD_W      = 64,
  parameter int               CMD_W     = 9,
  parameter int               GAP_CYC   = 4,
  parameter logic [CMD_W-1:0] NULL_CODE = 9'h1F0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xreq_i,
  input  logic [AD_W-1:0]  x_ad_i,
  input  logic [CMD_W-1:0] x_cmd_i,
  input  logic             x_done_i,
  output logic             own_o,
  input  logic             rd_vld_i,
  input  logic             rd_last_i,
  input  logic [AD_W-1:0]  rd_ad_i,
  input  logic [CMD_W-1:0] rd_cmd_i,
  input  logic             release_n_i,
  output logic             ext_rqst_n_o,
  output logic             valid_in_n_o,
  output logic [AD_W-1:0]  sys_ad_o,
  output logic [CMD_W-1:0] sys_cmd_o,
  output logic             bus_oe_o
);

  logic     start_req, grant_x, gap_ok;
  drv_sel_t sel_nxt;

  xh_req_ctl #(.GAP_CYC(GAP_CYC)) u_req (
    .clk          (clk),
    .rst          (rst),
    .start_req_i  (start_req),
    .grant_x_i    (grant_x),
    .ext_rqst_n_o (ext_rqst_n_o),
    .gap_ok_o     (gap_ok)
  );

  xh_own_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .release_n_i (release_n_i),
    .xreq_i      (xreq_i),
    .x_done_i    (x_done_i),
    .rd_vld_i    (rd_vld_i),
    .rd_last_i   (rd_last_i),
    .gap_ok_i    (gap_ok),
    .start_req_o (start_req),
    .grant_x_o   (grant_x),
    .sel_nxt_o   (sel_nxt),
    .own_o       (own_o)
  );

  xh_bus_drv #(
    .AD_W      (AD_W),
    .CMD_W     (CMD_W),
    .NULL_CODE (NULL_CODE)
  ) u_drv (
    .clk          (clk),
    .rst          (rst),
    .sel_i        (sel_nxt),
    .x_ad_i       (x_ad_i),
    .x_cmd_i      (x_cmd_i),
    .rd_ad_i      (rd_ad_i),
    .rd_cmd_i     (rd_cmd_i),
    .sys_ad_o     (sys_ad_o),
    .sys_cmd_o    (sys_cmd_o),
    .bus_oe_o     (bus_oe_o),
    .valid_in_n_o (valid_in_n_o)
  );

  // R9: never request while the buses are being driven
  p_no_req_while_drive_r9: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> ext_rqst_n_o);

  // R3: independent ownership always comes with a driven bus
  p_own_drives_r3: assert property (@(posedge clk) disable iff (rst)
    own_o |-> (bus_oe_o && valid_in_n_o));

  // R1: outputs are in their quiet state in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (ext_rqst_n_o && valid_in_n_o && !bus_oe_o && !own_o));

endmodule

// File: tb/ext_bus_handover_tb_top.sv
`timescale 1ns/1ps
module ext_bus_handover_tb_top;

  localparam int AD_W = 64;
  localparam int CMD_W = 9;
  localparam int GAP = 4;
  localparam logic [CMD_W-1:0] NULLC = 9'h1F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xreq = 0, x_done = 0, rd_vld = 0, rd_last = 0, rel_n = 1;
  logic [AD_W-1:0] x_ad = '0, rd_ad = '0;
  logic [CMD_W-1:0] x_cmd = '0, rd_cmd = '0;
  logic own, rqn, vin_n, oe;
  logic [AD_W-1:0] sad;
  logic [CMD_W-1:0] scmd;

  always #2.5 clk = ~clk;

  ext_bus_handover #(.AD_W(AD_W), .CMD_W(CMD_W), .GAP_CYC(GAP), .NULL_CODE(NULLC)) dut_i (
    .clk(clk), .rst(rst), .xreq_i(xreq), .x_ad_i(x_ad), .x_cmd_i(x_cmd),
    .x_done_i(x_done), .own_o(own), .rd_vld_i(rd_vld), .rd_last_i(rd_last),
    .rd_ad_i(rd_ad), .rd_cmd_i(rd_cmd), .release_n_i(rel_n),
    .ext_rqst_n_o(rqn), .valid_in_n_o(vin_n), .sys_ad_o(sad),
    .sys_cmd_o(scmd), .bus_oe_o(oe)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;

  // behavioural reference: 0 idle, 1 requesting, 2 own-xfer, 3 own-read, 4 hand-back
  int m_mode = 0, m_gap = 0;
  logic e_rqn = 1, e_vin = 1, e_oe = 0, e_own = 0;
  logic [AD_W-1:0] e_ad = '0;
  logic [CMD_W-1:0] e_cmd = '0;
  string m_tag = "R1";

  always @(posedge clk) begin
    int old_gap;
    started = 1;
    cyc++;
    if (rst) begin
      m_mode = 0; m_gap = 0; e_rqn = 1; e_vin = 1; e_oe = 0; e_own = 0;
      e_ad = '0; e_cmd = '0; m_tag = "R1";
    end else begin
      old_gap = m_gap;
      if (m_gap > 0) m_gap--;
      e_vin = 1; e_oe = 0; e_ad = '0; e_cmd = '0;
      case (m_mode)
        0: begin
          m_tag = (rd_vld || x_done) ? "R11" : "R2";
          if (!rel_n) begin
            m_mode = 3; e_oe = 1; m_tag = xreq ? "R10" : "R7";
          end else if (xreq && old_gap == 0) begin
            m_mode = 1; e_rqn = 0; m_tag = "R2";
          end else if (xreq) m_tag = "R4";
        end
        1: begin
          m_tag = "R2";
          if (!rel_n) begin
            m_mode = 2; e_rqn = 1; m_gap = GAP; e_oe = 1; e_ad = x_ad; e_cmd = x_cmd;
            m_tag = "R3";
          end
        end
        2: begin
          e_oe = 1;
          m_tag = !rel_n ? "R9" : (rd_vld ? "R11" : "R5");
          if (x_done) begin
            m_mode = 4; e_vin = 0; e_cmd = NULLC; m_tag = "R6";
          end else begin
            e_ad = x_ad; e_cmd = x_cmd;
          end
        end
        3: begin
          e_oe = 1;
          m_tag = !rel_n ? "R9" : (x_done ? "R11" : "R7");
          if (rd_vld) begin
            e_vin = 0; e_ad = rd_ad; e_cmd = rd_cmd; m_tag = "R8";
            if (rd_last) m_mode = 4;
          end
        end
        default: begin
          m_mode = 0; m_tag = "R6";
        end
      endcase
      e_own = (m_mode == 2);
    end
  end

  task automatic cmp1(string what, logic [AD_W-1:0] act, logic [AD_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", m_tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp1("ext_rqst_n", AD_W'(rqn), AD_W'(e_rqn));
      cmp1("valid_in_n", AD_W'(vin_n), AD_W'(e_vin));
      cmp1("bus_oe", AD_W'(oe), AD_W'(e_oe));
      cmp1("own", AD_W'(own), AD_W'(e_own));
      cmp1("sys_ad", sad, e_ad);
      cmp1("sys_cmd", AD_W'(scmd), AD_W'(e_cmd));
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic quiet();
    xreq = 0; x_done = 0; rd_vld = 0; rd_last = 0; rel_n = 1;
  endtask

  // independent transfer: request, late release, words, hand back
  task automatic xfer(int lat, int words);
    xreq = 1;
    while (rqn !== 1'b0) tick();
    tick(lat);
    rel_n = 0; tick(); rel_n = 1; xreq = 0;
    for (int w = 0; w < words; w++) begin
      x_ad = {32'hA5A5_0000, 32'(w)}; x_cmd = 9'(8'h10 + w);
      tick();
    end
    x_done = 1; tick(); x_done = 0; tick(2);
  endtask

  task automatic rd_burst(int words, int hole);
    rel_n = 0; tick(); rel_n = 1;
    tick(hole);
    for (int w = 0; w < words; w++) begin
      rd_vld = 1; rd_last = (w == words - 1);
      rd_ad = {32'hD00D_0000, 32'(w)}; rd_cmd = 9'(8'h40 + w);
      tick();
      if (w == 1) begin rd_vld = 0; tick(2); end
    end
    rd_vld = 0; rd_last = 0; tick(2);
  endtask

  initial begin
    tick(4);
    rst = 0;
    tick(2);
    // R2 R3 R5 R6
    xfer(3, 4);
    // R7 R8 block read with hole
    rd_burst(4, 2);
    // R8 one-word read answered in the first owned cycle
    rel_n = 0; tick(); rel_n = 1;
    rd_vld = 1; rd_last = 1; rd_ad = 64'h1234; rd_cmd = 9'h05; tick();
    rd_vld = 0; rd_last = 0; tick(3);
    // R9 release while owning, R11 stray strobes
    xreq = 1;
    while (rqn !== 1'b0) tick();
    rel_n = 0; tick(); xreq = 0; rel_n = 0; tick(); rel_n = 1;
    rd_vld = 1; tick(); rd_vld = 0; tick();
    x_done = 1; tick(); x_done = 0; tick(2);
    x_done = 1; rd_vld = 1; tick(); quiet(); tick(2);
    // R4 back-to-back requests with xreq held
    xreq = 1;
    for (int k = 0; k < 3; k++) begin
      while (rqn !== 1'b0) tick();
      rel_n = 0; tick(); rel_n = 1;
      x_done = 1; tick(); x_done = 0;
    end
    xreq = 0; tick(8);
    // R10 release and request in the same idle cycle
    xreq = 1; rel_n = 0; tick(); rel_n = 1;
    tick(2);
    rd_vld = 1; rd_last = 1; tick(); rd_vld = 0; rd_last = 0;
    while (rqn !== 1'b0) tick();
    rel_n = 0; tick(); rel_n = 1; xreq = 0;
    x_done = 1; tick(); quiet(); tick(3);
    // random mix of every input
    for (int i = 0; i < 4000; i++) begin
      rel_n = ($urandom_range(0, 5) != 0);
      xreq = ($urandom_range(0, 2) != 0);
      x_done = ($urandom_range(0, 4) == 0);
      rd_vld = ($urandom_range(0, 1) == 0);
      rd_last = ($urandom_range(0, 3) == 0);
      x_ad = {$urandom, $urandom}; rd_ad = {$urandom, $urandom};
      x_cmd = {1'b0, 8'($urandom)}; rd_cmd = {1'b0, 8'($urandom)};
      tick();
    end
    quiet(); tick(10);
    // R1 reset in the middle of activity
    xreq = 1; tick(3); rst = 1; tick(2); rst = 0; quiet(); tick(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule